// File: doc/BRIEF.md
# Indirect PHY Management Register Sequencer

This block gives a host a small byte-wide register window for reaching 16-bit management registers of an Ethernet PHY without handling the serial bus itself. The host fills an address byte and two data bytes, then writes a command byte. The command byte names the target, PHY or EEPROM, and the access type, read or write. For a PHY target the block runs a complete MDIO management frame on MDC and a tri-state MDIO pin. For a read it puts the returned word into the two data bytes.

For an EEPROM target the block does not run the serial protocol. It passes the request to an outside agent over a valid/ready port. The request (`ee_valid`, `ee_write`, `ee_addr`, `ee_wdata`) is held stable until the agent raises `ee_ready`. Read data on `ee_rdata` is taken in the cycle where both are high. The agent may apply back-pressure for any number of cycles by keeping `ee_ready` low.

The command bits stay set until software clears them. A typical PHY write is: address byte with bit 6 set (PHY 01), data high byte, data low byte, command 0x0A, then 0x08 to withdraw it.

Top module: `phy_mgmt_seq`

## Requirements
- R1: After reset, all four host registers read 0, `busy` is 0, `mdio_oe` is 0 and `ee_valid` is 0.
- R2: Host register index: 0 command, 1 address, 2 data low byte, 3 data high byte. In the command byte, bit 3 is the target (1 PHY, 0 EEPROM), bit 2 is read, bit 1 is write and bit 0 is a read-only busy flag. An access starts on a host write to the command byte with bit 2 or bit 1 set while not busy. Read wins if both are set. The hardware never clears the command bits.
- R3: `busy` (and command bit 0) is 1 from the clock edge that starts an access until the edge that completes it.
- R4: The MDIO PHY address is {000, address byte bits 7..6}. Only address byte bits 4..0 form the register address on the wire.
- R5: A PHY write drives all 64 frame bits: 32 ones, 01, opcode 01, PHY address, register address, turnaround 10, and the data word MSB first.
- R6: A PHY read sends opcode 10 and releases `mdio_oe` from frame bit 46 onward. It samples frame bits 48..63 MSB first into {data high, data low}.
- R7: MDC has a period of 2*MDC_HALF clocks. MDIO changes only together with a falling MDC and is sampled at a rising MDC.
- R8: An EEPROM command raises `ee_valid` with `ee_write` (1 for write), `ee_addr` = address byte bits 5..0 and `ee_wdata` = {data high, data low}. These stay stable until `ee_ready`. On a read, `ee_rdata` is loaded into the data bytes. MDIO stays undriven throughout.
- R9: While busy, a command write starts nothing and writes to the address and data bytes are ignored.
- R10: A command left set after completion does not start another access. Only a fresh command write does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Host register index |
| reg_wr | input | 1 | Host write strobe |
| reg_wdata | input | 8 | Host write byte |
| reg_rdata | output | 8 | Host read byte for `reg_sel` |
| busy | output | 1 | Access in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |
| ee_valid | output | 1 | EEPROM request valid |
| ee_ready | input | 1 | EEPROM request accepted / done |
| ee_write | output | 1 | EEPROM request is a write |
| ee_addr | output | 6 | EEPROM word address |
| ee_wdata | output | 16 | EEPROM write word |
| ee_rdata | input | 16 | EEPROM read word, valid with `ee_ready` |

## Verification
The bench sweeps every PHY address combination over register addresses that include bit 5 set, reconstructing each serial frame from the MDC edges. A design that leaked address bit 5 or swapped the PHY bits would show a wrong frame, and one that kept driving through the read turnaround would fight the PHY. Reads return the complement of the written word, so a bit-order or off-by-one sampling error lands wrong data in the byte registers. Writes during an access and a command bit left standing afterwards are both aimed at the relaunch and clobber paths. An EEPROM request held off by back-pressure must keep its fields stable and must leave MDIO alone.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
  localparam logic [1:0] SEL_CMD  = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DLO  = 2'd2;
  localparam logic [1:0] SEL_DHI  = 2'd3;

  localparam int CMD_TGT_BIT = 3;
  localparam int CMD_RD_BIT  = 2;
  localparam int CMD_WR_BIT  = 1;

  typedef struct packed {
    logic tgt_phy;
    logic rd;
    logic wr;
  } cmd_t;
endpackage

// File: rtl/mdc_clk_gen.sv
module mdc_clk_gen #(
  parameter int MDC_HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  logic wrap;

  generate
    if (MDC_HALF <= 1) begin : g_fast
      assign wrap = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(MDC_HALF);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == CW'(MDC_HALF - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign wrap = (cnt == CW'(MDC_HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) mdc <= 1'b0;
    else if (wrap) mdc <= ~mdc;
  end

  assign rise_tick = wrap & ~mdc;
  assign fall_tick = wrap & mdc;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng #(
  parameter int PRE_W  = 32,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              is_read,
  input  logic [4:0]        phy_adr,
  input  logic [4:0]        reg_adr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdc,
  input  logic              mdio_i,
  output logic              run,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int FRAME_BITS = PRE_W + 16 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int TA_BIT     = FRAME_BITS - DATA_W - 2;
  localparam int DAT_BIT    = FRAME_BITS - DATA_W;

  logic [FRAME_BITS-1:0] frame;
  logic [CNT_W-1:0]      cnt;
  logic                  rd_q;

  assign done = run && fall_tick && (cnt == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      frame   <= '0;
      rd_q    <= 1'b0;
      rdata   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else if (start && !run) begin
      run   <= 1'b1;
      cnt   <= '0;
      rd_q  <= is_read;
      rdata <= '0;
      frame <= {{PRE_W{1'b1}}, 2'b01, (is_read ? 2'b10 : 2'b01), phy_adr, reg_adr,
                (is_read ? 2'b00 : 2'b10), (is_read ? {DATA_W{1'b0}} : wdata)};
    end else if (run) begin
      if (fall_tick) begin
        if (done) begin
          run     <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          mdio_o  <= frame[FRAME_BITS-1];
          frame   <= frame << 1;
          mdio_oe <= !(rd_q && (cnt >= CNT_W'(TA_BIT)));
          cnt     <= cnt + 1'b1;
        end
      end
      if (rise_tick && rd_q && (cnt > CNT_W'(DAT_BIT)))
        rdata <= {rdata[DATA_W-2:0], mdio_i};
    end
  end

  assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run && !done |=> run);
  assert_oe_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run && rd_q && (cnt > CNT_W'(TA_BIT)) |-> !mdio_oe);
  assert_mdio_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) && !$fell(mdc) |-> $stable(mdio_o));
endmodule

// File: rtl/phy_mgmt_seq.sv
module phy_mgmt_seq
  import phy_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter int DATA_W   = 16,
  parameter int PRE_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              busy,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              ee_valid,
  input  logic              ee_ready,
  output logic              ee_write,
  output logic [5:0]        ee_addr,
  output logic [DATA_W-1:0] ee_wdata,
  input  logic [DATA_W-1:0] ee_rdata
);
  localparam int HB = DATA_W / 2;

  cmd_t              cmd_q;
  logic [7:0]        addr_q;
  logic [HB-1:0]     dlo_q, dhi_q;
  logic              op_rd_q;
  logic              eng_run, eng_done;
  logic [DATA_W-1:0] eng_rdata;
  logic              rise_tick, fall_tick;
  logic              cmd_wr, launch, ee_hs;

  assign cmd_wr = reg_wr && (reg_sel == SEL_CMD);
  assign launch = cmd_wr && !busy && (reg_wdata[CMD_RD_BIT] || reg_wdata[CMD_WR_BIT]);
  assign ee_hs  = ee_valid && ee_ready;
  assign busy   = eng_run || ee_valid;

  mdc_clk_gen #(.MDC_HALF(MDC_HALF)) u_mdc (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_eng #(.PRE_W(PRE_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .start(launch && reg_wdata[CMD_TGT_BIT]),
    .is_read(reg_wdata[CMD_RD_BIT]),
    .phy_adr({3'b000, addr_q[7:6]}),
    .reg_adr(addr_q[4:0]),
    .wdata({dhi_q, dlo_q}),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdc(mdc), .mdio_i(mdio_i),
    .run(eng_run), .done(eng_done), .rdata(eng_rdata),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      dlo_q    <= '0;
      dhi_q    <= '0;
      op_rd_q  <= 1'b0;
      ee_valid <= 1'b0;
      ee_write <= 1'b0;
    end else begin
      if (cmd_wr)
        cmd_q <= '{tgt_phy: reg_wdata[CMD_TGT_BIT], rd: reg_wdata[CMD_RD_BIT],
                   wr: reg_wdata[CMD_WR_BIT]};
      if (launch) begin
        op_rd_q <= reg_wdata[CMD_RD_BIT];
        if (!reg_wdata[CMD_TGT_BIT]) begin
          ee_valid <= 1'b1;
          ee_write <= !reg_wdata[CMD_RD_BIT];
        end
      end else if (ee_hs) begin
        ee_valid <= 1'b0;
      end
      if (eng_done && op_rd_q) begin
        {dhi_q, dlo_q} <= eng_rdata;
      end else if (ee_hs && !ee_write) begin
        {dhi_q, dlo_q} <= ee_rdata;
      end else if (reg_wr && !busy) begin
        if (reg_sel == SEL_DLO) dlo_q <= reg_wdata[HB-1:0];
        if (reg_sel == SEL_DHI) dhi_q <= reg_wdata[HB-1:0];
      end
      if (reg_wr && !busy && reg_sel == SEL_ADDR) addr_q <= reg_wdata;
    end
  end

  assign ee_addr  = addr_q[5:0];
  assign ee_wdata = {dhi_q, dlo_q};

  always_comb begin
    unique case (reg_sel)
      SEL_CMD:  reg_rdata = {4'b0000, cmd_q.tgt_phy, cmd_q.rd, cmd_q.wr, busy};
      SEL_ADDR: reg_rdata = addr_q;
      SEL_DLO:  reg_rdata = dlo_q;
      default:  reg_rdata = dhi_q;
    endcase
  end

  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_run |-> !ee_valid);
  assert_ee_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ee_valid && !ee_ready |=> ee_valid && $stable(ee_addr) && $stable(ee_write) && $stable(ee_wdata));
  assert_data_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(dlo_q) && $stable(dhi_q) && $stable(addr_q));
  assert_launch_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_sel == SEL_CMD));
endmodule

// File: tb/phy_mgmt_seq_test.sv
`timescale 1ns/1ps
module phy_mgmt_seq_test;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        busy, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b0;
  logic        ee_valid, ee_write;
  logic        ee_ready = 1'b0;
  logic [5:0]  ee_addr;
  logic [15:0] ee_wdata;
  logic [15:0] ee_rdata = 16'h0;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  phy_mgmt_seq #(.MDC_HALF(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i), .ee_valid(ee_valid), .ee_ready(ee_ready), .ee_write(ee_write),
    .ee_addr(ee_addr), .ee_wdata(ee_wdata), .ee_rdata(ee_rdata)
  );

  // PHY-side monitor: frame bit index counted from falling MDC edges
  int          fidx = 0;
  bit          mon_on = 1'b0;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_val = 16'h0;

  always @(negedge mdc) if (mon_on) begin
    fidx = fidx + 1;
    if (fidx - 1 >= 48 && fidx - 1 < 64) mdio_i = phy_val[64 - fidx];
  end
  always @(posedge mdc) if (mon_on && fidx >= 1 && fidx <= 64) begin
    cap_o[64 - fidx]  = mdio_o;
    cap_oe[64 - fidx] = mdio_oe;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic hr(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle(input string req);
    int k = 0;
    while (busy && k < 3000) begin @(negedge clk); k++; end
    chk(!busy, req, 64'(busy), 64'h0);
  endtask

  function automatic logic [63:0] exp_frame(bit rd, logic [1:0] p, logic [5:0] r, logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), 3'b000, p, r[4:0],
            (rd ? 2'b00 : 2'b10), (rd ? 16'h0 : d)};
  endfunction

  task automatic phy_op(input bit rd, input logic [1:0] p, input logic [5:0] r, input logic [15:0] d);
    logic [7:0]  b, lo, hi;
    logic [63:0] ef;
    hw(2'd1, {p, r});
    hw(2'd3, d[15:8]);
    hw(2'd2, d[7:0]);
    phy_val = ~d;
    hw(2'd0, rd ? 8'h0C : 8'h0A);
    fidx = 0; mon_on = 1'b1;
    chk(busy === 1'b1, "R3 busy after launch", 64'(busy), 64'h1);
    hr(2'd0, b);
    chk(b === (rd ? 8'h0D : 8'h0B), "R2 command readback", 64'(b), 64'(rd ? 8'h0D : 8'h0B));
    wait_idle("R3 busy clears");
    mon_on = 1'b0;
    ef = exp_frame(rd, p, r, d);
    if (rd) begin
      chk((cap_o >> 18) === (ef >> 18), "R4/R6 read frame header", cap_o, ef);
      chk(cap_oe === {{46{1'b1}}, 18'h0}, "R6 turnaround release", cap_oe, {{46{1'b1}}, 18'h0});
      hr(2'd2, lo); hr(2'd3, hi);
      chk({hi, lo} === ~d, "R6 read data", 64'({hi, lo}), 64'(~d));
    end else begin
      chk(cap_o === ef, "R4/R5 write frame", cap_o, ef);
      chk(cap_oe === '1, "R5 write drive", cap_oe, '1);
    end
    repeat (20) @(negedge clk);
    chk(busy === 1'b0, "R10 no relaunch from standing command", 64'(busy), 64'h0);
    hw(2'd0, 8'h08);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [7:0] b;
    int t0, t1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      hr(2'(s), b);
      chk(b === 8'h00, "R1 register reset", 64'(b), 64'h0);
    end
    chk(!busy && !mdio_oe && !ee_valid, "R1 outputs idle", {busy, mdio_oe, ee_valid}, 64'h0);

    // R7 MDC period
    @(posedge mdc); t0 = 0;
    while (1) begin @(posedge clk); t0++; #0.1 if (mdc == 1'b0) break; end
    t1 = 0;
    while (1) begin @(posedge clk); t1++; #0.1 if (mdc == 1'b1) break; end
    chk(t0 + t1 == 2 * HALF, "R7 MDC period", 64'(t0 + t1), 64'(2 * HALF));

    // near-exhaustive sweep: all PHY address bits, several register addresses
    for (int p = 0; p < 4; p++) begin
      for (int ri = 0; ri < 4; ri++) begin
        logic [5:0]  r;
        logic [15:0] d;
        r = (ri == 0) ? 6'h00 : (ri == 1) ? 6'h1F : (ri == 2) ? 6'h25 : 6'h3A;
        d = 16'hA5C3 ^ (16'(p) * 16'h1111) ^ {10'h0, r};
        phy_op(1'b0, 2'(p), r, d);
        phy_op(1'b1, 2'(p), r, d);
      end
    end

    // R9: writes during an access are ignored and do not relaunch
    hw(2'd1, 8'h41); hw(2'd3, 8'h12); hw(2'd2, 8'h34);
    hw(2'd0, 8'h0A);
    fidx = 0; mon_on = 1'b1;
    repeat (10) @(negedge clk);
    hw(2'd3, 8'hFF); hw(2'd1, 8'h00); hw(2'd0, 8'h0C);
    wait_idle("R9 first access completes");
    mon_on = 1'b0;
    chk(cap_o === exp_frame(1'b0, 2'b01, 6'h01, 16'h1234), "R9 frame undisturbed",
        cap_o, exp_frame(1'b0, 2'b01, 6'h01, 16'h1234));
    hr(2'd3, b);
    chk(b === 8'h12, "R9 data byte write ignored", 64'(b), 64'h12);
    hr(2'd1, b);
    chk(b === 8'h41, "R9 address write ignored", 64'(b), 64'h41);
    repeat (300) @(negedge clk);
    chk(busy === 1'b0 && mdio_oe === 1'b0, "R9 busy command not queued", 64'(busy), 64'h0);
    hw(2'd0, 8'h08);

    // R8 EEPROM read with back-pressure
    hw(2'd1, 8'hEA);
    hw(2'd0, 8'h04);
    chk(ee_valid === 1'b1 && ee_write === 1'b0 && ee_addr === 6'h2A, "R8 EEPROM read request",
        {ee_valid, ee_write, ee_addr}, {1'b1, 1'b0, 6'h2A});
    repeat (5) @(negedge clk);
    chk(ee_valid === 1'b1 && busy === 1'b1 && ee_addr === 6'h2A, "R8 request held",
        {ee_valid, busy}, 64'h3);
    chk(mdio_oe === 1'b0, "R8 MDIO undriven", 64'(mdio_oe), 64'h0);
    ee_rdata = 16'hBEEF; ee_ready = 1'b1;
    @(negedge clk);
    ee_ready = 1'b0;
    chk(ee_valid === 1'b0 && busy === 1'b0, "R8 handshake completes", {ee_valid, busy}, 64'h0);
    hr(2'd3, b);
    chk(b === 8'hBE, "R8 read data high", 64'(b), 64'hBE);
    hr(2'd2, b);
    chk(b === 8'hEF, "R8 read data low", 64'(b), 64'hEF);
    hw(2'd0, 8'h00);

    // R8 EEPROM write
    hw(2'd1, 8'h15); hw(2'd3, 8'h5A); hw(2'd2, 8'h3C);
    hw(2'd0, 8'h02);
    chk(ee_valid && ee_write && ee_addr === 6'h15 && ee_wdata === 16'h5A3C,
        "R8 EEPROM write request", {ee_write, ee_addr, ee_wdata}, {1'b1, 6'h15, 16'h5A3C});
    ee_ready = 1'b1;
    @(negedge clk);
    ee_ready = 1'b0;
    chk(!ee_valid && !busy, "R8 write handshake", {ee_valid, busy}, 64'h0);
    hr(2'd2, b);
    chk(b === 8'h3C, "R8 write leaves data", 64'(b), 64'h3C);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule